// File: doc/BRIEF.md
# ALU with Class-Selective Condition Flags

This block is a two's complement arithmetic logic unit for N-bit operands. Its result and four condition flags (zero, negative, carry, overflow) are held in registers. A caller presents two operands and a 4-bit operation code, and raises a strobe for one cycle. On that clock edge the block computes the operation, writes the result register and updates the flags.

Each family of operations updates only its own subset of flags. Arithmetic operations update all four flags. Bitwise operations update only zero and negative. Single-bit shifts update only carry and zero. Flags outside the family keep their earlier values, so a branch decision can still use a carry produced several operations back.

Subtract, decrement and negate all run through the one adder that add uses. The adder receives the inverted operand, or an all-ones constant, with carry-in set high where needed. Compare performs the subtraction for its flags only and leaves the result register unchanged.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low, `res_q` and all four flags are 0.
- R2: ADD (code 0) writes A+B modulo 2^N. INC (code 2) writes A+1. C is the carry out of the top bit. V is the carry into the top bit XOR the carry out of it, so operands of opposite sign never set V.
- R3: SUB (code 1) writes A−B, computed as A + ~B with carry-in 1. DEC (code 3) writes A−1. C is the raw adder carry, so C=1 means no borrow. V flags signed overflow.
- R4: NEG (code 4) writes 0−A. Negating the most negative value gives that same value and sets V. Negating 0 sets C.
- R5: For codes 0 to 4 and 12, Z is 1 exactly when the arithmetic result is all zeros, N copies its top bit, and all four flags are updated.
- R6: AND (5), OR (6), XOR (7) and NOT of A (8) write the bitwise result. They update Z and N only, and C and V keep their values.
- R7: SHL (9) shifts A left by one and C receives the old top bit. SHR (10) fills the top bit with 0 and C receives the old bit 0. SRA (11) fills the top bit with the sign, and C receives the old bit 0. Shifts update C and Z only, and N and V keep their values.
- R8: CMP (12) sets Z, N, C and V exactly as SUB would, and leaves `res_q` unchanged.
- R9: When `in_valid` is low, or when the code is 13, 14 or 15, neither `res_q` nor any flag changes.
- R10: The result and flags of a strobed operation appear after the rising edge that samples the strobe. Before that edge the outputs still show the previous state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: perform the operation on this edge |
| op_sel | input | 4 | Operation code (see requirements) |
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| res_q | output | W | Result register |
| flg_z | output | 1 | Zero flag |
| flg_n | output | 1 | Negative flag |
| flg_c | output | 1 | Carry flag |
| flg_v | output | 1 | Overflow flag |

## Verification
Every strobed operation, and every idle cycle, has its effect due at the first rising edge after the inputs are driven. That is one register stage, for the result and the flags alike. The driver applies inputs on the falling edge and queues the expected state. The monitor takes one item from the queue per rising edge and compares 2 ns after that edge, once the registers have settled. One probe also reads the outputs 1 ns after the inputs change, before any edge, to confirm that nothing moves early.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_NEG = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOT = 4'd8,
    OP_SHL = 4'd9,
    OP_SHR = 4'd10,
    OP_SRA = 4'd11,
    OP_CMP = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_LOGIC = 2'd2,
    CLS_SHIFT = 2'd3
  } op_class_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         c_into_msb
);

  logic [W:0] cy;

  assign cy[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]   = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1]  = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  assign cout       = cy[W];
  assign c_into_msb = cy[W-1];

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu_shift1.sv
module alu_shift1
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         spill
);

  localparam int MSB = W - 1;

  always_comb begin
    case (op)
      OP_SHL: begin
        res   = {a[MSB-1:0], 1'b0};
        spill = a[MSB];
      end
      OP_SHR: begin
        res   = {1'b0, a[MSB:1]};
        spill = a[0];
      end
      OP_SRA: begin
        res   = {a[MSB], a[MSB:1]};
        spill = a[0];
      end
      default: begin
        res   = a;
        spill = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res_q,
  output logic         flg_z,
  output logic         flg_n,
  output logic         flg_c,
  output logic         flg_v
);

  localparam int MSB = W - 1;
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  op_e          op_v;
  op_class_e    cls;
  logic         wr_res;
  logic [W-1:0] add_a, add_b, add_sum;
  logic         add_ci, add_co, add_cm;
  logic [W-1:0] lg_res, sh_res, val;
  logic         sh_spill;
  logic [W-1:0] res_d, res_r;
  flags_t       flags_d, flags_r;

  assign op_v = op_e'(op_sel);

  // Operand steering: every arithmetic code goes through the one adder
  always_comb begin
    add_a  = opa;
    add_b  = opb;
    add_ci = 1'b0;
    cls    = CLS_NONE;
    wr_res = 1'b0;
    case (op_v)
      OP_ADD: begin cls = CLS_ARITH; wr_res = 1'b1; end
      OP_SUB: begin cls = CLS_ARITH; wr_res = 1'b1; add_b = ~opb; add_ci = 1'b1; end
      OP_CMP: begin cls = CLS_ARITH; add_b = ~opb; add_ci = 1'b1; end
      OP_INC: begin cls = CLS_ARITH; wr_res = 1'b1; add_b = '0; add_ci = 1'b1; end
      OP_DEC: begin cls = CLS_ARITH; wr_res = 1'b1; add_b = '1; end
      OP_NEG: begin cls = CLS_ARITH; wr_res = 1'b1; add_a = '0; add_b = ~opa; add_ci = 1'b1; end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin cls = CLS_LOGIC; wr_res = 1'b1; end
      OP_SHL, OP_SHR, OP_SRA: begin cls = CLS_SHIFT; wr_res = 1'b1; end
      default: begin cls = CLS_NONE; end
    endcase
  end

  alu_ripple_add #(.W(W)) u_add (
    .a(add_a), .b(add_b), .cin(add_ci),
    .sum(add_sum), .cout(add_co), .c_into_msb(add_cm)
  );

  alu_bitwise #(.W(W)) u_bit (
    .op(op_v), .a(opa), .b(opb), .res(lg_res)
  );

  alu_shift1 #(.W(W)) u_shf (
    .op(op_v), .a(opa), .res(sh_res), .spill(sh_spill)
  );

  // Next state: each class touches only its own flags
  always_comb begin
    case (cls)
      CLS_LOGIC: val = lg_res;
      CLS_SHIFT: val = sh_res;
      default:   val = add_sum;
    endcase
    res_d   = res_r;
    flags_d = flags_r;
    if (wr_res) res_d = val;
    case (cls)
      CLS_ARITH: begin
        flags_d.z = (add_sum == '0);
        flags_d.n = add_sum[MSB];
        flags_d.c = add_co;
        flags_d.v = add_cm ^ add_co;
      end
      CLS_LOGIC: begin
        flags_d.z = (lg_res == '0);
        flags_d.n = lg_res[MSB];
      end
      CLS_SHIFT: begin
        flags_d.z = (sh_res == '0);
        flags_d.c = sh_spill;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_r   <= '0;
      flags_r <= '0;
    end else if (in_valid) begin
      res_r   <= res_d;
      flags_r <= flags_d;
    end
  end

  assign res_q = res_r;
  assign flg_z = flags_r.z;
  assign flg_n = flags_r.n;
  assign flg_c = flags_r.c;
  assign flg_v = flags_r.v;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(res_q) && $stable({flg_z, flg_n, flg_c, flg_v})); // R9
  AST_UNUSED_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_sel > 4'd12) |=> $stable(res_q) && $stable({flg_z, flg_n, flg_c, flg_v})); // R9
  AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_sel == 4'd12) |=> $stable(res_q)); // R8
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_sel >= 4'd5 && op_sel <= 4'd8) |=> $stable(flg_c) && $stable(flg_v)); // R6
  AST_SHIFT_KEEPS_NV: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_sel >= 4'd9 && op_sel <= 4'd11) |=> $stable(flg_n) && $stable(flg_v)); // R7
  AST_MIXED_SIGN_NO_V: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_sel == 4'd0 && (opa[MSB] != opb[MSB])) |=> !flg_v); // R2
  AST_NEG_MIN_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_sel == 4'd4 && opa == MOST_NEG) |=> flg_v && res_q == MOST_NEG); // R4
  AST_ARITH_ZN_TRACK: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op_sel <= 4'd4) |=> (flg_z == (res_q == '0)) && (flg_n == res_q[MSB])); // R5

endmodule

// File: tb/alu_flag_unit_tb_top.sv
`timescale 1ns/1ps
module alu_flag_unit_tb_top;

  localparam int W = 8;

  typedef struct {
    logic [W-1:0] res;
    logic z, n, c, v;
    string tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [3:0]   op_sel;
  logic [W-1:0] opa, opb;
  logic [W-1:0] res_q;
  logic         flg_z, flg_n, flg_c, flg_v;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  exp_t q[$];

  // bench model state
  logic [W-1:0] m_res = '0;
  logic m_z = 0, m_n = 0, m_c = 0, m_v = 0;

  alu_flag_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .res_q(res_q),
    .flg_z(flg_z), .flg_n(flg_n), .flg_c(flg_c), .flg_v(flg_v)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check_state(input string tag, input logic [W-1:0] er,
                             input logic ez, en, ec, ev);
    total++;
    if ({res_q, flg_z, flg_n, flg_c, flg_v} !== {er, ez, en, ec, ev}) begin
      bad++;
      $display("FAIL %s: actual res=%h znvc z=%b n=%b c=%b v=%b, expected res=%h z=%b n=%b c=%b v=%b",
               tag, res_q, flg_z, flg_n, flg_c, flg_v, er, ez, en, ec, ev);
    end
  endtask

  // Driver: apply on falling edge, update the model, queue the expectation
  task automatic drive(input logic vld, input logic [3:0] o,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input string tag);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         c, v, wr;
    int           cls; // 0 none, 1 arith, 2 logic, 3 shift
    exp_t         e;
    @(negedge clk);
    in_valid = vld; op_sel = o; opa = a; opb = b;
    r = '0; c = 0; v = 0; wr = 1; cls = 0;
    case (o)
      4'd0: begin s = {1'b0, a} + {1'b0, b}; r = s[W-1:0]; c = s[W];
                  v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); cls = 1; end
      4'd1, 4'd12: begin r = a - b; c = (a >= b);
                  v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); cls = 1; wr = (o == 4'd1); end
      4'd2: begin r = a + 1'b1; c = (a == 8'hFF); v = (a == 8'h7F); cls = 1; end
      4'd3: begin r = a - 1'b1; c = (a != 8'h00); v = (a == 8'h80); cls = 1; end
      4'd4: begin r = 8'h00 - a; c = (a == 8'h00); v = (a == 8'h80); cls = 1; end
      4'd5: begin r = a & b; cls = 2; end
      4'd6: begin r = a | b; cls = 2; end
      4'd7: begin r = a ^ b; cls = 2; end
      4'd8: begin r = ~a; cls = 2; end
      4'd9: begin r = a << 1; c = a[W-1]; cls = 3; end
      4'd10: begin r = a >> 1; c = a[0]; cls = 3; end
      4'd11: begin r = {a[W-1], a[W-1:1]}; c = a[0]; cls = 3; end
      default: begin cls = 0; wr = 0; end
    endcase
    if (vld) begin
      if (cls != 0 && wr) m_res = r;
      if (cls == 1) begin m_z = (r == '0); m_n = r[W-1]; m_c = c; m_v = v; end
      if (cls == 2) begin m_z = (r == '0); m_n = r[W-1]; end
      if (cls == 3) begin m_z = (r == '0); m_c = c; end
    end
    e.res = m_res; e.z = m_z; e.n = m_n; e.c = m_c; e.v = m_v; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: one expectation per rising edge, compared after it settles
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        #2;
        check_state(e.tag, e.res, e.z, e.n, e.c, e.v);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pr;
    logic pz, pn, pc, pv;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    check_state("R1 reset", 8'h00, 0, 0, 0, 0);
    rst_n = 1'b1;

    drive(1, 4'd0, 8'h50, 8'h30, "R2 add pos+pos overflow");
    drive(1, 4'd0, 8'hF0, 8'h20, "R2 add mixed sign carry no V");
    drive(1, 4'd0, 8'h80, 8'h80, "R2 R5 add neg+neg to zero");
    drive(1, 4'd2, 8'h7F, 8'h00, "R2 inc max positive");
    drive(1, 4'd2, 8'hFF, 8'h00, "R2 R5 inc wrap zero");
    drive(1, 4'd1, 8'd45, 8'd73, "R3 sub borrow");
    drive(1, 4'd1, 8'h80, 8'h01, "R3 sub signed overflow");
    drive(1, 4'd3, 8'h00, 8'h00, "R3 dec from zero");
    drive(1, 4'd3, 8'h01, 8'h00, "R3 dec to zero");
    drive(1, 4'd4, 8'h80, 8'h00, "R4 neg most negative");
    drive(1, 4'd4, 8'h00, 8'h00, "R4 neg zero");
    drive(1, 4'd4, 8'h05, 8'h00, "R4 neg five");

    drive(1, 4'd0, 8'h80, 8'h80, "R6 prime C V");
    drive(1, 4'd5, 8'hF0, 8'h0F, "R6 and keeps C V");
    drive(1, 4'd6, 8'hA0, 8'h05, "R6 or");
    drive(1, 4'd7, 8'hFF, 8'h0F, "R6 xor");
    drive(1, 4'd8, 8'hFF, 8'h00, "R6 not");

    drive(1, 4'd4, 8'h80, 8'h00, "R7 prime N V");
    drive(1, 4'd9, 8'h81, 8'h00, "R7 shl spill msb");
    drive(1, 4'd10, 8'h81, 8'h00, "R7 shr zero fill");
    drive(1, 4'd11, 8'h81, 8'h00, "R7 sra sign fill");
    drive(1, 4'd9, 8'h00, 8'h00, "R7 shl zero");
    drive(1, 4'd11, 8'h02, 8'h00, "R7 sra positive");

    drive(1, 4'd0, 8'h12, 8'h22, "R8 set result");
    drive(1, 4'd12, 8'h10, 8'h20, "R8 cmp less");
    drive(1, 4'd12, 8'h33, 8'h33, "R8 cmp equal");

    drive(0, 4'd0, 8'hFF, 8'h01, "R9 idle add");
    drive(0, 4'd8, 8'h00, 8'h00, "R9 idle not");
    drive(1, 4'd13, 8'hFF, 8'hFF, "R9 code 13");
    drive(1, 4'd15, 8'h00, 8'h00, "R9 code 15");

    pr = m_res; pz = m_z; pn = m_n; pc = m_c; pv = m_v;
    drive(1, 4'd0, 8'h01, 8'h01, "R10 after edge");
    #1;
    check_state("R10 before edge", pr, pz, pn, pc, pv);

    drive(0, 4'd0, 8'h00, 8'h00, "R9 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule